// File: doc/BRIEF.md
# Serial DAC Control Interface

This block is the digital front end of a serially loaded 8-bit current-output converter. A host drives three wires into it: an active-low frame select, a serial clock and serial data. Each frame carries 16 bits, most significant bit first. The top four bits form a command and the next eight bits form a converter code. The block keeps the converter code register and presents it as a parallel output. It also drives a serial data output. That output either repeats the previous frame so that several devices can be chained, or returns the code register after a readback command.

All three serial inputs pass through a two-stage synchronizer into the system clock domain. Serial clock edges are found by comparing each synchronized sample with the one before it. The edge that samples data can be chosen at run time. After reset it is the falling edge. A command can switch sampling to the rising edge, and another command switches it back. The serial output always changes on the edge that does not sample.

Top module: `dac_serial_front`

## Requirements
- R1: A frame is latched on the 16th active serial clock edge counted after frame select goes low. Further serial clock edges in the same frame have no effect on any output.
- R2: While frame select is high, serial clock and serial data have no effect on `dac_code`, `sdo` or `sample_rising`.
- R3: Synchronous reset sets `dac_code` to 0, `sdo` to 0 and `sample_rising` to 0, which selects falling-edge sampling.
- R4: Command 4'b1011 in bits [15:12] sets `sample_rising` to 1, so later frames are sampled on the rising edge. Command 4'b1100 sets it back to 0. The setting holds across frames until one of these commands or a reset changes it.
- R5: `sdo` changes only on the serial clock edge opposite the sampling edge, or when frame select falls. At frame select fall it presents the first outgoing bit.
- R6: In the frame after a completed frame with any command except readback, `sdo` carries that previous 16-bit word, MSB first. Each bit is valid at the sampling edge where it is expected.
- R7: After a frame with command 4'b0010, the next frame carries {4'b0000, dac_code, 4'b0000} on `sdo`, MSB first.
- R8: Command 4'b0001 copies frame bits [11:4] into `dac_code`. Every other command value leaves `dac_code` unchanged. Bits [3:0] are ignored.
- R9: If frame select rises before 16 active edges, the frame is discarded. `dac_code` and `sample_rising` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is registered on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| frame_n | input | 1 | Frame select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdin | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, for chaining or readback |
| dac_code | output | 8 | Parallel converter code register |
| sample_rising | output | 1 | 1 when data is sampled on the rising serial clock edge |

## Verification
The assertions assume that every serial clock level and every frame select level lasts at least three system clocks. This lets the synchronizer see each transition as exactly one edge. They also assume that frame select never falls in the same system cycle as a serial clock edge. The bench holds each serial clock phase for eight system clocks. It sets data and frame select half a serial period away from any edge. While frame select is high, it parks the serial clock at the level that matches the current sampling mode.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    typedef enum logic [3:0] {
        CMD_NOP       = 4'b0000,
        CMD_LOAD      = 4'b0001,
        CMD_READBACK  = 4'b0010,
        CMD_EDGE_RISE = 4'b1011,
        CMD_EDGE_FALL = 4'b1100
    } fe_cmd_e;

    // index of each serial pin inside the synchronizer vector
    localparam int PIN_FRAME = 0;
    localparam int PIN_SCLK  = 1;
    localparam int PIN_SDIN  = 2;
    localparam int PIN_COUNT = 3;

endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    // stages 0..STAGES-1 synchronize, stage STAGES keeps the previous sample
    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] pipe_d [DEPTH];
    logic [WIDTH-1:0] pipe_q [DEPTH];

    always_comb begin
        pipe_d[0] = pin_i;
        for (int s = 1; s < DEPTH; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) pipe_q[g] <= RST_VAL;
                else     pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign sync_o = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/dac_fe_decode.sv
module dac_fe_decode
    import dac_fe_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CMD_W   = 4,
    parameter int CODE_W  = 8
) (
    input  logic [FRAME_W-1:0] word_i,
    input  logic [CODE_W-1:0]  code_now_i,
    output logic               load_o,
    output logic               readback_o,
    output logic               set_rise_o,
    output logic               clr_rise_o,
    output logic [CODE_W-1:0]  code_o,
    output logic [FRAME_W-1:0] readback_word_o
);
    localparam int PAD_W = FRAME_W - CMD_W - CODE_W;

    logic [CMD_W-1:0] cmd;

    always_comb begin
        cmd             = word_i[FRAME_W-1 -: CMD_W];
        code_o          = word_i[FRAME_W-CMD_W-1 -: CODE_W];
        load_o          = (cmd == CMD_W'(CMD_LOAD));
        readback_o      = (cmd == CMD_W'(CMD_READBACK));
        set_rise_o      = (cmd == CMD_W'(CMD_EDGE_RISE));
        clr_rise_o      = (cmd == CMD_W'(CMD_EDGE_FALL));
        readback_word_o = {{CMD_W{1'b0}}, code_now_i, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dac_fe_pkg::*;
#(
    parameter int FRAME_W = 16,
    parameter int CMD_W   = 4,
    parameter int CODE_W  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_n,
    input  logic              sclk,
    input  logic              sdin,
    output logic              sdo,
    output logic [CODE_W-1:0] dac_code,
    output logic              sample_rising
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] sreg;
        logic [CNT_W-1:0]   cnt;
        logic [CODE_W-1:0]  code;
        logic               rise_mode;
        logic               sdo;
    } fe_state_t;

    fe_state_t st_d, st_q;

    logic [PIN_COUNT-1:0] pins, pin_s, pin_p;

    assign pins[PIN_FRAME] = frame_n;
    assign pins[PIN_SCLK]  = sclk;
    assign pins[PIN_SDIN]  = sdin;

    dac_fe_sync #(
        .WIDTH   (PIN_COUNT),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_COUNT'(1) << PIN_FRAME)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pins),
        .sync_o (pin_s),
        .prev_o (pin_p)
    );

    logic frame_s, in_frame, start, sclk_up, sclk_dn, samp, shift_out, latch;
    logic [FRAME_W-1:0] word, rb_word;
    logic               dec_load, dec_read, dec_rise, dec_fall;
    logic [CODE_W-1:0]  dec_code;

    always_comb begin
        frame_s   = pin_s[PIN_FRAME];
        in_frame  = ~frame_s;
        start     = in_frame & pin_p[PIN_FRAME];
        sclk_up   = pin_s[PIN_SCLK] & ~pin_p[PIN_SCLK];
        sclk_dn   = ~pin_s[PIN_SCLK] & pin_p[PIN_SCLK];
        samp      = st_q.rise_mode ? sclk_up : sclk_dn;
        shift_out = st_q.rise_mode ? sclk_dn : sclk_up;
        word      = {st_q.sreg[FRAME_W-2:0], pin_s[PIN_SDIN]};
        latch     = in_frame & ~start & samp & (st_q.cnt == CNT_LAST);
    end

    dac_fe_decode #(
        .FRAME_W (FRAME_W),
        .CMD_W   (CMD_W),
        .CODE_W  (CODE_W)
    ) u_dec (
        .word_i          (word),
        .code_now_i      (st_q.code),
        .load_o          (dec_load),
        .readback_o      (dec_read),
        .set_rise_o      (dec_rise),
        .clr_rise_o      (dec_fall),
        .code_o          (dec_code),
        .readback_word_o (rb_word)
    );

    always_comb begin
        st_d = st_q;
        if (!in_frame) begin
            st_d.cnt = '0;
        end else if (start) begin
            st_d.cnt = '0;
            st_d.sdo = st_q.sreg[FRAME_W-1];
        end else if (st_q.cnt < CNT_FULL) begin
            if (samp) begin
                st_d.sreg = word;
                st_d.cnt  = st_q.cnt + 1'b1;
                if (latch) begin
                    if (dec_load) st_d.code = dec_code;
                    if (dec_read) st_d.sreg = rb_word;
                    if (dec_rise) st_d.rise_mode = 1'b1;
                    if (dec_fall) st_d.rise_mode = 1'b0;
                end
            end else if (shift_out) begin
                st_d.sdo = st_q.sreg[FRAME_W-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sdo           = st_q.sdo;
    assign dac_code      = st_q.code;
    assign sample_rising = st_q.rise_mode;
endmodule

// File: rtl/dac_fe_checker.sv
module dac_fe_checker #(
    parameter int FRAME_W = 16,
    parameter int CODE_W  = 8,
    parameter int CNT_W   = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_s,
    input logic              samp,
    input logic              start,
    input logic              latch,
    input logic [CNT_W-1:0]  cnt,
    input logic              sdo,
    input logic              rise_mode,
    input logic [CODE_W-1:0] code
);
    // R1: the edge counter never runs past one full frame
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_W));

    // R2: with frame select high the counter clears and the code holds
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        frame_s |=> (cnt == '0) && $stable(code));

    // R4: sampling mode changes only on a latched frame
    p_mode_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(rise_mode));

    // R5: a sampling edge never moves serial data out
    p_sdo_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (samp && !start) |=> $stable(sdo));

    // R8: the code register moves only on a latched frame
    p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(code));
endmodule

bind dac_serial_front dac_fe_checker #(
    .FRAME_W (FRAME_W),
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .frame_s   (frame_s),
    .samp      (samp),
    .start     (start),
    .latch     (latch),
    .cnt       (st_q.cnt),
    .sdo       (sdo),
    .rise_mode (sample_rising),
    .code      (dac_code)
);

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;
    localparam int H = 8;   // system clocks per serial clock phase

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_n = 1'b1;
    logic sclk = 1'b1;
    logic sdin = 1'b0;
    logic sdo;
    logic [7:0] dac_code;
    logic sample_rising;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit b_rise = 1'b0;
    logic [15:0] got;

    always #2 clk = ~clk;   // 250 MHz

    dac_serial_front dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .sclk(sclk), .sdin(sdin),
        .sdo(sdo), .dac_code(dac_code), .sample_rising(sample_rising)
    );

    // ---------------- behavioural reference model ----------------
    bit   hA [3], hB [3], hC [3];   // pin history: frame, sclk, sdin
    bit   mq [$];                   // shift contents, front = MSB
    int   mcnt;
    int   mdac;
    bit   mrise, msdo;

    function automatic void model_reset();
        mq.delete();
        for (int i = 0; i < 16; i++) mq.push_back(1'b0);
        mcnt = 0; mdac = 0; mrise = 0; msdo = 0;
        hA = '{1, 0, 0}; hB = '{1, 0, 0}; hC = '{1, 0, 0};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            model_reset();
        end else begin
            bit up, dn, se, oe;
            up = hB[1] && !hC[1];
            dn = !hB[1] && hC[1];
            se = mrise ? up : dn;
            oe = mrise ? dn : up;
            if (hB[0]) begin
                mcnt = 0;
            end else if (hC[0]) begin
                mcnt = 0;
                msdo = mq[0];
            end else if (mcnt < 16) begin
                if (se) begin
                    void'(mq.pop_front());
                    mq.push_back(hB[2]);
                    mcnt++;
                    if (mcnt == 16) begin
                        int c, v;
                        c = 0; v = 0;
                        for (int i = 0; i < 4; i++)  c = c * 2 + mq[i];
                        for (int i = 4; i < 12; i++) v = v * 2 + mq[i];
                        if (c == 1) mdac = v;
                        if (c == 11) mrise = 1;
                        if (c == 12) mrise = 0;
                        if (c == 2) begin
                            int d;
                            d = mdac;
                            mq.delete();
                            for (int i = 0; i < 16; i++)
                                mq.push_back((i >= 4 && i < 12) ? ((d >> (11 - i)) & 1) : 1'b0);
                        end
                    end
                end else if (oe) begin
                    msdo = mq[0];
                end
            end
        end
        hC = hB; hB = hA; hA = '{frame_n, sclk, sdin};
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            tests++;
            if (dac_code !== 8'(mdac) || sample_rising !== mrise || sdo !== msdo) begin
                fails++;
                $display("FAIL model R8/R4/R5 cycle %0d: dac=%h/%h rise=%b/%b sdo=%b/%b",
                         cycles, dac_code, 8'(mdac), sample_rising, mrise, sdo, msdo);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(logic [15:0] w, int nbits);
        got = '0;
        frame_n = 1'b0;
        idle(H);
        for (int i = 0; i < nbits; i++) begin
            sdin = (i < 16) ? w[15 - i] : 1'b1;
            idle(H);
            if (i < 16) got[15 - i] = sdo;
            sclk = b_rise ? 1'b1 : 1'b0;    // sampling edge
            idle(H);
            sclk = b_rise ? 1'b0 : 1'b1;    // shift-out edge
        end
        idle(H);
        frame_n = 1'b1;
        idle(2 * H);
    endtask

    task automatic set_mode(bit r);
        b_rise = r;
        sclk = r ? 1'b0 : 1'b1;
        idle(2 * H);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        idle(5);
        rst = 1'b0;
        idle(4);
        check("R3 reset dac", dac_code, 0);
        check("R3 reset edge", sample_rising, 0);
        check("R3 reset sdo", sdo, 0);

        send(16'h1A50, 16);
        check("R8 load A5", dac_code, 8'hA5);
        check("R1 latched after 16 edges", dac_code, 8'hA5);

        send(16'h03C5, 16);
        check("R8 nop keeps dac", dac_code, 8'hA5);
        check("R6 chain out prev word", got, 16'h1A50);

        send(16'h1420, 16);
        check("R6 chain out nop word", got, 16'h03C5);
        check("R8 load 42", dac_code, 8'h42);

        send(16'h2000, 16);
        check("R8 readback keeps dac", dac_code, 8'h42);
        send(16'h0000, 16);
        check("R7 readback stream", got, 16'h0420);

        send(16'h1FF0, 10);
        check("R9 aborted frame", dac_code, 8'h42);
        send(16'h1770, 16);
        check("R9 count restarts", dac_code, 8'h77);

        // R2: toggle serial pins with frame select high
        begin
            logic s0;
            s0 = sdo;
            for (int i = 0; i < 20; i++) begin
                sdin = i[0];
                sclk = ~sclk;
                idle(H);
            end
            sclk = 1'b1;
            idle(2 * H);
            check("R2 dac ignored idle", dac_code, 8'h77);
            check("R2 sdo ignored idle", sdo, s0);
            check("R2 mode ignored idle", sample_rising, 0);
        end

        send(16'hB000, 16);
        check("R4 rising set", sample_rising, 1);
        set_mode(1'b1);
        send(16'h1C30, 16);
        check("R4 load in rising mode", dac_code, 8'hC3);
        check("R5 sdo valid at rising sample", got, 16'hB000);

        send(16'h1110, 20);
        check("R1 extra edges ignored", dac_code, 8'h11);
        check("R4 mode persists", sample_rising, 1);

        send(16'hC000, 16);
        check("R4 falling restored", sample_rising, 0);
        set_mode(1'b0);
        send(16'h15A0, 16);
        check("R8 load in falling mode", dac_code, 8'h5A);
        check("R5 sdo valid at falling sample", got, 16'hC000);

        send(16'h7FF0, 16);
        check("R8 unused command", dac_code, 8'h5A);

        send(16'hB000, 16);
        set_mode(1'b1);
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        set_mode(1'b0);
        check("R3 reset clears mode", sample_rising, 0);
        check("R3 reset clears dac", dac_code, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule